// File: doc/BRIEF.md
# Decade Clock Divider with Edge-Aligned Outputs

This block divides a fast reference clock by a decade ratio and produces two square waves from it: one at half the reference rate and one at one tenth of it (for the default ratio of ten). A single modulo counter serves both. Its lowest bit gives the half-rate wave. Its terminal-count pulse gives the slow wave: the pulse sets a flop, and the same pulse, delayed by half the ratio in a shift register, clears it again.

Each output passes through registers sized so that all rising edges fall on the same reference edge. A downstream decade stage that registers its own output once on the exported strobe therefore also rises on that edge. The strobe is the terminal count delayed by one register. It is one reference cycle wide and serves as the clock enable for further decade stages.

Cycle numbering used below: n = 0 is the first cycle after a clock edge that sampled reset high, and n grows by one at each edge while reset is low. The counter holds n mod DIV.

Top module: `decade_edge_divider`

## Requirements
- R1: `tc_strobe` is high in cycle n exactly when n ≥ DIV and n mod DIV = 0. It is one cycle wide and recurs every DIV cycles.
- R2: `half_out` is the counter's lowest bit delayed by two true (non-inverted) register stages. It is low in cycles 0 to 2 and, from then on, high exactly in the odd cycles.
- R3: Every rising edge of `tenth_out` coincides with a rising edge of `half_out` and with the cycle after a `tc_strobe` pulse.
- R4: `tenth_out` is low in cycles 0 to DIV. After that it is high exactly when (n − 1) mod DIV < DIV/2.
- R5: Once running, `tenth_out` has a 50% duty cycle: exactly DIV/2 cycles high, then DIV/2 cycles low.
- R6: Inside the block, the square-wave flop is set on the cycle after each terminal count and cleared DIV/2 cycles later by the delayed copy of the same pulse.
- R7: A synchronous `rst` that is high at a clock edge drives all three outputs low after that edge, whenever it arrives. After release the sequence restarts from n = 0.
- R8: The counter holds values 0 to DIV−1 only, and moves from DIV−1 back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| half_out | output | 1 | Half-rate square wave, edge aligned |
| tenth_out | output | 1 | Rate divided by DIV, 50% duty, edge aligned |
| tc_strobe | output | 1 | One-cycle enable for lower decade stages |

## Verification
The bench builds two copies side by side from the same clock and reset. One uses the default ratio DIV = 10. The other uses DIV = 6, which shortens the stretcher to three stages and changes where the terminal count and the clear pulse fall. The second copy shows whether the alignment and duty rules follow the parameter or only hold for ten. Both copies are compared every cycle with sequences the bench computes from n, across a start from reset and a reset issued partway through a period.

// File: rtl/dd_pkg.sv
package dd_pkg;
  // Next value of a counter that wraps after `limit` states.
  function automatic int unsigned wrap_inc(int unsigned c, int unsigned limit);
    return (c + 1 >= limit) ? 0 : c + 1;
  endfunction

  // True on the last state before the wrap.
  function automatic logic at_last(int unsigned c, int unsigned limit);
    return c == limit - 1;
  endfunction
endpackage

// File: rtl/dd_mod_counter.sv
module dd_mod_counter #(
  parameter int DIV = 10,
  localparam int CW = $clog2(DIV)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] count,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= CW'(dd_pkg::wrap_inc(32'(count), DIV));
  end

  assign last = dd_pkg::at_last(32'(count), DIV);
endmodule

// File: rtl/dd_pulse_stretcher.sv
module dd_pulse_stretcher #(
  parameter int HOLD = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic level,
  output logic clear
);
  logic [HOLD-1:0] delay_q;

  always_ff @(posedge clk) begin
    if (rst) delay_q <= '0;
    else     delay_q <= {delay_q[HOLD-2:0], trig};
  end

  assign clear = delay_q[HOLD-1];

  // Set/reset flop: set wins on a coincidence.
  always_ff @(posedge clk) begin
    if (rst)        level <= 1'b0;
    else if (trig)  level <= 1'b1;
    else if (clear) level <= 1'b0;
  end
endmodule

// File: rtl/dd_align_pipe.sv
module dd_align_pipe #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES:0] tap;
  assign tap[0] = d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) tap[i+1] <= 1'b0;
      else     tap[i+1] <= tap[i];
    end
  end

  assign q = tap[STAGES];
endmodule

// File: rtl/decade_edge_divider.sv
module decade_edge_divider #(
  parameter int DIV = 10,
  localparam int CW       = $clog2(DIV),
  localparam int HOLD     = DIV / 2,
  localparam int HALF_LAG = 2,
  localparam int SLOW_LAG = 1
) (
  input  logic clk,
  input  logic rst,
  output logic half_out,
  output logic tenth_out,
  output logic tc_strobe
);
  logic [CW-1:0] cnt_w;
  logic          tc_w;
  logic          sq_w;
  logic          clr_w;

  dd_mod_counter #(.DIV(DIV)) u_count (
    .clk(clk), .rst(rst), .count(cnt_w), .last(tc_w)
  );

  dd_pulse_stretcher #(.HOLD(HOLD)) u_stretch (
    .clk(clk), .rst(rst), .trig(tc_w), .level(sq_w), .clear(clr_w)
  );

  dd_align_pipe #(.STAGES(HALF_LAG)) u_half_pipe (
    .clk(clk), .rst(rst), .d(cnt_w[0]), .q(half_out)
  );

  dd_align_pipe #(.STAGES(SLOW_LAG)) u_slow_pipe (
    .clk(clk), .rst(rst), .d(sq_w), .q(tenth_out)
  );

  dd_align_pipe #(.STAGES(1)) u_strobe_pipe (
    .clk(clk), .rst(rst), .d(tc_w), .q(tc_strobe)
  );
endmodule

// File: rtl/dd_checker.sv
module dd_checker #(
  parameter int DIV = 10,
  localparam int CW = $clog2(DIV)
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] cnt,
  input logic          tc,
  input logic          sq,
  input logic          clr,
  input logic          half_out,
  input logic          tenth_out,
  input logic          tc_strobe
);
  logic [1:0] seen;
  always_ff @(posedge clk) begin
    if (rst)               seen <= '0;
    else if (seen != 2'd3) seen <= seen + 2'd1;
  end

  p_range_r8: assert property (@(posedge clk) disable iff (rst)
    (seen != 2'd0) |-> (32'(cnt) < DIV));
  p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (32'(cnt) == DIV - 1) |=> (cnt == '0));
  p_strobe_phase_r1: assert property (@(posedge clk) disable iff (rst)
    tc_strobe |-> (cnt == '0));
  p_half_lag_r2: assert property (@(posedge clk) disable iff (rst)
    (seen == 2'd3) |-> (half_out == $past(cnt[0], 2)));
  p_align_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(tenth_out) |-> ($rose(half_out) && $past(tc_strobe)));
  p_set_r6: assert property (@(posedge clk) disable iff (rst)
    tc |=> sq);
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (clr && !tc) |=> !sq);
  p_slow_lag_r4: assert property (@(posedge clk) disable iff (rst)
    (seen != 2'd0) |-> (tenth_out == $past(sq)));
  p_reset_r7: assert property (@(posedge clk)
    rst |=> (!half_out && !tenth_out && !tc_strobe));
endmodule

bind decade_edge_divider dd_checker #(.DIV(DIV)) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt_w), .tc(tc_w), .sq(sq_w), .clr(clr_w),
  .half_out(half_out), .tenth_out(tenth_out), .tc_strobe(tc_strobe)
);

// File: tb/test_decade_edge_divider.sv
`timescale 1ns/1ps
module test_decade_edge_divider;
  localparam int DA = 10;
  localparam int DB = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ha, ta, sa, hb, tb, sb;
  int checks = 0;
  int errors = 0;
  int n = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  decade_edge_divider #(.DIV(DA)) i_decade_edge_divider (
    .clk(clk), .rst(rst), .half_out(ha), .tenth_out(ta), .tc_strobe(sa));
  decade_edge_divider #(.DIV(DB)) i_decade_edge_divider_d6 (
    .clk(clk), .rst(rst), .half_out(hb), .tenth_out(tb), .tc_strobe(sb));

  // Expected sequences restated from the requirements, per cycle index k.
  function automatic bit exp_half(int k);     // R2
    return (k > 2) && (k % 2 == 1);
  endfunction
  function automatic bit exp_tenth(int k, int d); // R4
    return (k > d) && (((k - 1) % d) < d / 2);
  endfunction
  function automatic bit exp_strobe(int k, int d); // R1
    return (k >= d) && (k % d == 0);
  endfunction

  task automatic ck(string req, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%0b expected=%0b", req, n, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    n = 0;
    ck("R7 half", ha, 1'b0); ck("R7 tenth", ta, 1'b0); ck("R7 strobe", sa, 1'b0);
    ck("R7 half d6", hb, 1'b0); ck("R7 tenth d6", tb, 1'b0); ck("R7 strobe d6", sb, 1'b0);
    rst = 1'b0;
  endtask

  // Step cycles, comparing every output of both copies against the model.
  task automatic run_checked(int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      ck("R2 half", ha, exp_half(n));
      ck("R2 half d6", hb, exp_half(n));
      ck("R4 tenth", ta, exp_tenth(n, DA));
      ck("R4 tenth d6", tb, exp_tenth(n, DB));
      ck("R1 strobe", sa, exp_strobe(n, DA));
      ck("R1 strobe d6", sb, exp_strobe(n, DB));
      if (ta && !exp_tenth(n - 1, DA)) ck("R3 align", ha, 1'b1);
    end
  endtask

  // R5: count high cycles over whole periods of the DIV=10 copy.
  task automatic duty_check();
    int hi_a = 0;
    int hi_b = 0;
    for (int i = 0; i < DA * DB; i++) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      hi_a += int'(ta);
      hi_b += int'(tb);
    end
    checks++;
    if (hi_a != DB * (DA / 2)) begin
      errors++;
      $display("FAIL R5 duty: actual=%0d expected=%0d", hi_a, DB * (DA / 2));
    end
    checks++;
    if (hi_b != DA * (DB / 2)) begin
      errors++;
      $display("FAIL R5 duty d6: actual=%0d expected=%0d", hi_b, DA * (DB / 2));
    end
  endtask

  task automatic test_startup();   // R1 R2 R3 R4 R7 R8
    apply_reset();
    run_checked(4 * DA + 3);
  endtask

  task automatic test_midrun_reset(); // R7
    run_checked(7);
    apply_reset();
    run_checked(3 * DA);
  endtask

  task automatic test_duty();      // R5 R6
    duty_check();
    run_checked(0);
  endtask

  initial begin
    test_startup();
    test_midrun_reset();
    test_duty();
    test_midrun_reset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule